// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a watchdog timer whose control settings can only change through a two-write unlock ritual on a small register bus. The first write arms the lock with a fixed password word. The next write must carry a second password byte. When it does, that write also supplies the run flag, a stored power field, a tick-clock select and a 16-bit reload value. A prescaler turns the free-running input clock into slow ticks, and each tick decrements a 16-bit down-counter.

Software keeps the system alive by repeating the full two-write sequence, which reloads the counter. If the counter runs out while the timer is enabled, the block raises a one-cycle reset request and switches itself off. It also sets a sticky cause flag. That flag survives the system reset it triggered and is cleared only by a power-on reset. A second-password write with the run flag clear stops the timer.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset, the control word (offset 0x0), the status word (offset 0x8) and the cause word (offset 0x4) all read 0, and the reset request is low.
- R2: A write to offset 0x0 whose whole 32-bit value is 0x00BE0000 arms the unlock. A write of any other value leaves the unlock unarmed.
- R3: When the unlock is armed, the next write to offset 0x0 with 0xDC in bits 23:16 commits the configuration: run flag from bit 31, power field from bits 27:26, clock select from bits 25:24 and reload from bits 15:0. Offset 0x0 reads those fields back at the same positions, with every other bit 0.
- R4: While armed, any other write disarms the unlock and leaves the configuration unchanged. This covers a wrong password byte, a write to another offset, and a repeated 0x00BE0000. A commit-shaped write that follows is then ignored.
- R5: A commit-shaped write that arrives while the unlock is not armed has no effect.
- R6: Offset 0x8 reads the run flag in bit 31, the power field in bits 27:26, the clock select in bits 25:24 and the live counter in bits 15:0. All other bits read 0.
- R7: Each commit loads the counter with the reload value. The counter then decreases by one every PRESCALE clock cycles, but only while the run flag is 1 and the clock select is 3. Otherwise the counter holds its value.
- R8: With reload N, the reset request goes high for exactly one cycle, PRESCALE*max(N,1) cycles after the commit. At the same moment the run flag clears and the counter reads 0.
- R9: A new full unlock sequence reloads the counter and restarts the prescaler. It takes priority over a tick that falls in the same cycle, so expiry moves to PRESCALE*N cycles after the new commit.
- R10: A commit with the run flag clear stops the timer. No reset request follows, and the counter holds the reload value written in that commit.
- R11: Expiry sets bit 31 of offset 0x4. The bit survives the system reset and is cleared only by the power-on reset.
- R12: The system reset clears the configuration, the counter and the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low; clears the timer but not the cause flag |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with PRESCALE set to 4 instead of the default 262144. With that value a tick falls every four cycles, so a complete countdown, the expiry pulse and the sticky cause flag all happen within a few dozen cycles. The small ratio also makes it cheap to place a keep-alive commit on exactly the edge where a tick lands, and to check an expiry that starts from a reload of zero.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  localparam logic [7:0]  PW_ARM    = 8'hBE;
  localparam logic [7:0]  PW_COMMIT = 8'hDC;
  localparam logic [31:0] ARM_WORD  = {8'h00, PW_ARM, 16'h0000};
  localparam logic [1:0]  CSEL_RUN  = 2'b11;
  localparam int          RELOAD_W  = 16;

  localparam int OFF_CTRL  = 'h0;
  localparam int OFF_CAUSE = 'h4;
  localparam int OFF_STAT  = 'h8;

  typedef enum logic {UL_IDLE, UL_ARMED} unlock_t;

  typedef struct packed {
    logic                run;
    logic [1:0]          pwr;
    logic [1:0]          csel;
    logic [RELOAD_W-1:0] reload;
  } wdt_cfg_t;

  function automatic logic [7:0] pw_byte(input logic [31:0] w);
    return w[23:16];
  endfunction

  function automatic logic is_arm(input logic [31:0] w);
    return w == ARM_WORD;
  endfunction

  function automatic wdt_cfg_t cfg_decode(input logic [31:0] w);
    wdt_cfg_t c;
    c.run    = w[31];
    c.pwr    = w[27:26];
    c.csel   = w[25:24];
    c.reload = w[15:0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input wdt_cfg_t c,
                                           input logic [RELOAD_W-1:0] low);
    return {c.run, 3'b000, c.pwr, c.csel, 8'h00, low};
  endfunction

  function automatic logic ticking(input wdt_cfg_t c);
    return c.run && (c.csel == CSEL_RUN);
  endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_other,
  input  logic [31:0] wdata,
  output logic        armed,
  output logic        commit
);

  unlock_t state;
  logic    any_wr;

  assign any_wr = wr_ctrl || wr_other;
  assign armed  = (state == UL_ARMED);
  assign commit = armed && wr_ctrl && (pw_byte(wdata) == PW_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= UL_IDLE;
    end else if (armed && any_wr) begin
      state <= UL_IDLE;
    end else if (wr_ctrl && is_arm(wdata)) begin
      state <= UL_ARMED;
    end
  end

  // R4
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && any_wr) |=> !armed);

  // R2
  arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_ctrl) |=> !armed);

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 262144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt;

      assign tick = run && (pcnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcnt <= '0;
        end else if (restart || !run || tick) begin
          pcnt <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end

      // R9
      restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         expire
);

  logic step;

  assign step   = run && tick && !load;
  assign expire = step && (count <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step && count != '0) begin
      count <= count - 1'b1;
    end
  end

  // R7
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));

  // R8
  zero_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == '0));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PRESCALE = 262144
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_reset_req
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic                core_rst_n;
  logic                wr_ctrl, wr_other;
  logic                armed, commit;
  logic                run, tick, expire;
  logic [RELOAD_W-1:0] count;
  logic                cause;
  wdt_cfg_t            cfg;
  wdt_cfg_t            new_cfg;

  assign core_rst_n = por_n && rst_n;
  assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
  assign wr_other   = bus_we && (bus_addr != A_CTRL);
  assign new_cfg    = cfg_decode(bus_wdata);
  assign run        = ticking(cfg);

  wdt_unlock u_unlock (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_other (wr_other),
    .wdata    (bus_wdata),
    .armed    (armed),
    .commit   (commit)
  );

  wdt_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .run     (run),
    .restart (commit),
    .tick    (tick)
  );

  wdt_countdown #(.W(RELOAD_W)) u_count (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (commit),
    .load_val (new_cfg.reload),
    .run      (run),
    .tick     (tick),
    .count    (count),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cfg           <= '0;
      wdt_reset_req <= 1'b0;
    end else begin
      wdt_reset_req <= expire;
      if (commit) begin
        cfg <= new_cfg;
      end else if (expire) begin
        cfg.run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause <= 1'b0;
    end else if (expire) begin
      cause <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = cfg_pack(cfg, cfg.reload);
      A_STAT:  bus_rdata = cfg_pack(cfg, count);
      A_CAUSE: bus_rdata = {cause, 31'b0};
      default: bus_rdata = '0;
    endcase
  end

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  // R8
  self_stop_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    wdt_reset_req |-> !cfg.run);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!commit && !expire) |=> $stable(cfg));

  // R11
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> cause);

  // R11
  cause_follow_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    wdt_reset_req |-> cause);

endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;

  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_guard #(.ADDR_W(4), .PRESCALE(PRE)) u_wdt_guard (
    .clk           (clk),
    .por_n         (por_n),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .wdt_reset_req (wdt_reset_req)
  );

  // {addr, write data, expected control readback} - R2 R3 R4 R5
  localparam logic [67:0] VEC [19] = '{
    {4'h0, 32'h80DC0005, 32'h00000000},  // R5 commit shape, not armed
    {4'h0, 32'h00BE0001, 32'h00000000},  // R2 near-miss arm word
    {4'h0, 32'h80DC0005, 32'h00000000},  // R5 still locked
    {4'h0, 32'h00BE0000, 32'h00000000},  // R2 arm
    {4'h0, 32'h86DC0123, 32'h86000123},  // R3 commit
    {4'h0, 32'h00DC0000, 32'h86000123},  // R5 bare DC unarmed
    {4'h0, 32'h00BE0000, 32'h86000123},
    {4'h0, 32'h00AB0000, 32'h86000123},  // R4 wrong byte
    {4'h0, 32'h88DC0777, 32'h86000123},
    {4'h0, 32'h00BE0000, 32'h86000123},
    {4'h8, 32'h00000000, 32'h86000123},  // R4 other offset
    {4'h0, 32'h88DC0777, 32'h86000123},
    {4'h0, 32'h00BE0000, 32'h86000123},
    {4'h0, 32'h00BE0000, 32'h86000123},  // R4 repeated arm
    {4'h0, 32'h88DC0777, 32'h86000123},
    {4'h0, 32'h00BE0000, 32'h86000123},
    {4'h0, 32'h8CDC0042, 32'h8C000042},  // R3 second commit
    {4'h0, 32'h00BE0000, 32'h8C000042},
    {4'h0, 32'h00DC0000, 32'h00000000}   // R10 stop
  };

  function automatic int expiry_cycles(input int n);
    return PRE * ((n == 0) ? 1 : n);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock_write(input logic [31:0] d);
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, d);
  endtask

  // polls from the current negedge; first = cycle index of the first high, highs = count
  task automatic watch(input int n, output int first, output int highs);
    first = 0;
    highs = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wdt_reset_req) begin
        highs++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int first, highs;

    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(4'h8, v); check(v == 0, "R1 status", v, 0);
    rd(4'h4, v); check(v == 0, "R1 cause", v, 0);
    check(wdt_reset_req == 0, "R1 reset_req", {31'b0, wdt_reset_req}, 0);

    // table walk: unlock rules, readback at 0x0 and 0x8 (no tick: select != 3)
    foreach (VEC[k]) begin
      wr(VEC[k][67:64], VEC[k][63:32]);
      rd(4'h0, v); check(v == VEC[k][31:0], "R3/R4 ctrl", v, VEC[k][31:0]);
      rd(4'h8, v); check(v == VEC[k][31:0], "R6 status", v, VEC[k][31:0]);
    end

    // R7 R8 R11 full countdown, reload 3
    unlock_write(32'h83DC0003);
    first = 0; highs = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (wdt_reset_req) begin
        highs++;
        if (first == 0) first = i;
      end
      if (i == PRE - 1) begin
        rd(4'h8, v); check(v == 32'h83000003, "R7 before tick", v, 32'h83000003);
      end
      if (i == PRE) begin
        rd(4'h8, v); check(v == 32'h83000002, "R6 R7 after tick", v, 32'h83000002);
      end
    end
    check(first == expiry_cycles(3), "R8 expiry cycle", first, expiry_cycles(3));
    check(highs == 1, "R8 one-cycle pulse", highs, 1);
    rd(4'h8, v); check(v == 32'h03000000, "R8 self stop", v, 32'h03000000);
    rd(4'h4, v); check(v == 32'h80000000, "R11 cause set", v, 32'h80000000);

    // R11 R12 system reset keeps cause, clears timer and unlock
    wr(4'h0, 32'h00BE0000);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(4'h4, v); check(v == 32'h80000000, "R11 cause survives", v, 32'h80000000);
    rd(4'h0, v); check(v == 0, "R12 ctrl cleared", v, 0);
    wr(4'h0, 32'h81DC0009);
    rd(4'h0, v); check(v == 0, "R12 unlock cleared", v, 0);

    // R9 keep-alive commit on a tick edge
    unlock_write(32'h83DC0003);
    watch(2 * PRE - 2, first, highs);
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, 32'h83DC0003);
    check(highs == 0, "R9 no early pulse", highs, 0);
    rd(4'h8, v); check(v == 32'h83000003, "R9 reloaded", v, 32'h83000003);
    watch(16, first, highs);
    check(first == expiry_cycles(3), "R9 restarted expiry", first, expiry_cycles(3));

    // R10 stop
    unlock_write(32'h83DC0002);
    watch(3, first, highs);
    unlock_write(32'h00DC0000);
    watch(40, first, highs);
    check(highs == 0 && first == 0, "R10 no pulse", highs, 0);
    rd(4'h8, v); check(v == 0, "R10 count held", v, 0);

    // R7 select other than 3 holds the count
    unlock_write(32'h81DC0001);
    watch(20, first, highs);
    check(highs == 0, "R7 no tick sel1", highs, 0);
    rd(4'h8, v); check(v == 32'h81000001, "R7 held sel1", v, 32'h81000001);

    // R8 reload 0
    unlock_write(32'h83DC0000);
    watch(10, first, highs);
    check(first == expiry_cycles(0), "R8 reload zero", first, expiry_cycles(0));

    // R11 power-on reset clears cause
    por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    rd(4'h4, v); check(v == 0, "R11 cause cleared", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule